// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function field of a 32-bit load/store instruction into the control levels that a single-cycle datapath needs in the same cycle. It is purely combinational. Its outputs choose the destination register, enable the register write, and select sign or zero extension. They also choose the second ALU operand, drive the data-memory read and write strobes, and pick memory or ALU data for writeback. Three further outputs flag an equal-branch, a not-equal-branch and a jump.

The ALU operation is found in two stages. The opcode stage assigns each instruction an operation class. When the opcode is zero, the class means "use the function field", and a second stage turns the function field into one of six fixed 4-bit ALU codes. Outputs that an instruction does not use are driven to 0. An opcode or function code that is not recognised drives all controls to 0 and raises an illegal flag, so the datapath around the decoder changes no state.

Top module: `ctrl_decode_unit`

## Requirements
- R1: With opcode 0x00 and a known function code, dst_rd_o=1, reg_we_o=1, alu_b_imm_o=0 and imm_sx_o=0, and every memory, writeback-source and branch output is 0.
- R2: With opcode 0x00, function codes 0x20, 0x22, 0x24, 0x25, 0x26 and 0x2A give alu_code_o 0000 (add), 0010 (subtract), 0100 (and), 0101 (or), 0110 (xor) and 1010 (set-less-than).
- R3: Opcodes 0x08, 0x0A, 0x0C, 0x0D and 0x0E give alu_code_o 0000, 1010, 0100, 0101 and 0110, with reg_we_o=1, alu_b_imm_o=1 and dst_rd_o=0.
- R4: imm_sx_o is 1 for opcodes 0x08, 0x0A, 0x23 and 0x2B, and 0 for 0x0C, 0x0D and 0x0E.
- R5: Opcode 0x23 (load) sets mem_rd_o, wb_mem_o, reg_we_o, alu_b_imm_o and imm_sx_o, with alu_code_o 0000 and mem_wr_o=0.
- R6: Opcode 0x2B (store) sets mem_wr_o, alu_b_imm_o and imm_sx_o, with alu_code_o 0000 and reg_we_o=0, mem_rd_o=0.
- R7: Opcode 0x04 sets br_eq_o and opcode 0x05 sets br_ne_o. Both give alu_code_o 0010 and alu_b_imm_o=0, and no register or memory write.
- R8: Opcode 0x02 sets jump_o, and every other control output and alu_code_o is 0.
- R9: Outputs that an instruction does not use are 0. For example, a store has dst_rd_o=0 and wb_mem_o=0, and a branch has imm_sx_o=0.
- R10: Any opcode outside {0x00,0x02,0x04,0x05,0x08,0x0A,0x0C,0x0D,0x0E,0x23,0x2B} gives illegal_o=1, with every control output 0 and alu_code_o 0000.
- R11: Opcode 0x00 with a function code outside the six listed in R2 gives illegal_o=1, with every control output 0 and alu_code_o 0000.
- R12: illegal_o is 0 for each of the sixteen supported encodings.
- R13: When the opcode is not 0x00, the function field has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction opcode field |
| funct_i | input | 6 | Instruction function field |
| dst_rd_o | output | 1 | 1: write the third register field; 0: write the second |
| reg_we_o | output | 1 | Register file write enable |
| imm_sx_o | output | 1 | 1: sign-extend the 16-bit immediate; 0: zero-extend |
| alu_b_imm_o | output | 1 | 1: second ALU operand is the immediate |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| wb_mem_o | output | 1 | 1: writeback data comes from memory |
| br_eq_o | output | 1 | Branch-if-equal instruction |
| br_ne_o | output | 1 | Branch-if-not-equal instruction |
| jump_o | output | 1 | Unconditional jump instruction |
| alu_code_o | output | 4 | ALU operation code |
| illegal_o | output | 1 | Encoding is not supported |

## Verification
The bench targets these corner cases:
- The zero-extending logic immediates sit next to the sign-extending arithmetic ones. A decoder that lumps them together would corrupt operands in andi, ori and xori.
- Function codes are swept under opcode 0x00. A decoder that falls back to a default operation would write a register for an undefined instruction instead of raising the illegal flag.
- Function codes are also applied with nonzero opcodes. A decoder that consults the function field too widely would change the ALU code of immediate or memory instructions.
- Every unused opcode is swept. A partial case statement would leave a stray memory write or branch active.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 4;
  localparam int NCTL  = 10;

  typedef logic [OP_W-1:0]  op_t;
  typedef logic [FN_W-1:0]  fn_t;
  typedef logic [ALU_W-1:0] alu_t;

  localparam alu_t ALU_ADD = 4'b0000;
  localparam alu_t ALU_SUB = 4'b0010;
  localparam alu_t ALU_AND = 4'b0100;
  localparam alu_t ALU_OR  = 4'b0101;
  localparam alu_t ALU_XOR = 4'b0110;
  localparam alu_t ALU_SLT = 4'b1010;

  // operation class produced by the opcode stage
  typedef enum logic [2:0] {
    CLS_NONE, CLS_FUNCT, CLS_ADD, CLS_SUB, CLS_AND, CLS_OR, CLS_XOR, CLS_SLT
  } alu_cls_e;

  localparam op_t OPC_REG  = 6'h00;
  localparam op_t OPC_JMP  = 6'h02;
  localparam op_t OPC_BEQ  = 6'h04;
  localparam op_t OPC_BNE  = 6'h05;
  localparam op_t OPC_ADDI = 6'h08;
  localparam op_t OPC_SLTI = 6'h0A;
  localparam op_t OPC_ANDI = 6'h0C;
  localparam op_t OPC_ORI  = 6'h0D;
  localparam op_t OPC_XORI = 6'h0E;
  localparam op_t OPC_LD   = 6'h23;
  localparam op_t OPC_ST   = 6'h2B;

  localparam fn_t FN_ADD = 6'h20;
  localparam fn_t FN_SUB = 6'h22;
  localparam fn_t FN_AND = 6'h24;
  localparam fn_t FN_OR  = 6'h25;
  localparam fn_t FN_XOR = 6'h26;
  localparam fn_t FN_SLT = 6'h2A;

  typedef struct packed {
    logic dst_rd;
    logic reg_we;
    logic imm_sx;
    logic b_imm;
    logic mem_rd;
    logic mem_wr;
    logic wb_mem;
    logic br_eq;
    logic br_ne;
    logic jump;
  } ctl_t;
endpackage

// File: rtl/op_stage.sv
module op_stage
  import ctrl_dec_pkg::*;
(
  input  op_t      opcode_i,
  output ctl_t     ctl_o,
  output alu_cls_e cls_o,
  output logic     op_bad_o
);
  always_comb begin
    ctl_o    = '0;
    cls_o    = CLS_NONE;
    op_bad_o = 1'b0;
    unique case (opcode_i)
      OPC_REG: begin
        ctl_o.dst_rd = 1'b1;
        ctl_o.reg_we = 1'b1;
        cls_o        = CLS_FUNCT;
      end
      OPC_ADDI, OPC_SLTI: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.imm_sx = 1'b1;
        ctl_o.b_imm  = 1'b1;
        cls_o        = (opcode_i == OPC_ADDI) ? CLS_ADD : CLS_SLT;
      end
      OPC_ANDI, OPC_ORI, OPC_XORI: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.b_imm  = 1'b1;
        cls_o        = (opcode_i == OPC_ANDI) ? CLS_AND :
                       (opcode_i == OPC_ORI)  ? CLS_OR  : CLS_XOR;
      end
      OPC_LD: begin
        ctl_o.reg_we = 1'b1;
        ctl_o.imm_sx = 1'b1;
        ctl_o.b_imm  = 1'b1;
        ctl_o.mem_rd = 1'b1;
        ctl_o.wb_mem = 1'b1;
        cls_o        = CLS_ADD;
      end
      OPC_ST: begin
        ctl_o.imm_sx = 1'b1;
        ctl_o.b_imm  = 1'b1;
        ctl_o.mem_wr = 1'b1;
        cls_o        = CLS_ADD;
      end
      OPC_BEQ: begin
        ctl_o.br_eq = 1'b1;
        cls_o       = CLS_SUB;
      end
      OPC_BNE: begin
        ctl_o.br_ne = 1'b1;
        cls_o       = CLS_SUB;
      end
      OPC_JMP: ctl_o.jump = 1'b1;
      default: op_bad_o = 1'b1;
    endcase
  end

  // R7
  always_comb begin
    branch_no_write_chk: assert (!((ctl_o.br_eq || ctl_o.br_ne) &&
                                   (ctl_o.reg_we || ctl_o.mem_wr || ctl_o.b_imm)))
      else $error("branch drives a write or immediate operand");
  end
endmodule

// File: rtl/alu_stage.sv
module alu_stage
  import ctrl_dec_pkg::*;
(
  input  alu_cls_e cls_i,
  input  fn_t      funct_i,
  output alu_t     code_o,
  output logic     fn_bad_o
);
  alu_t fn_code;
  logic fn_known;

  always_comb begin
    fn_known = 1'b1;
    fn_code  = ALU_ADD;
    unique case (funct_i)
      FN_ADD:  fn_code = ALU_ADD;
      FN_SUB:  fn_code = ALU_SUB;
      FN_AND:  fn_code = ALU_AND;
      FN_OR:   fn_code = ALU_OR;
      FN_XOR:  fn_code = ALU_XOR;
      FN_SLT:  fn_code = ALU_SLT;
      default: fn_known = 1'b0;
    endcase
  end

  always_comb begin
    fn_bad_o = 1'b0;
    unique case (cls_i)
      CLS_FUNCT: begin
        code_o   = fn_known ? fn_code : ALU_ADD;
        fn_bad_o = !fn_known;
      end
      CLS_SUB: code_o = ALU_SUB;
      CLS_AND: code_o = ALU_AND;
      CLS_OR:  code_o = ALU_OR;
      CLS_XOR: code_o = ALU_XOR;
      CLS_SLT: code_o = ALU_SLT;
      default: code_o = ALU_ADD;
    endcase
  end

  // R13
  always_comb begin
    funct_scope_chk: assert (!(fn_bad_o && cls_i != CLS_FUNCT))
      else $error("function field consulted outside register class");
  end
endmodule

// File: rtl/ctrl_decode_unit.sv
module ctrl_decode_unit
  import ctrl_dec_pkg::*;
#(
  parameter int OPW  = OP_W,
  parameter int FNW  = FN_W,
  parameter int ALUW = ALU_W
) (
  input  logic [OPW-1:0]  opcode_i,
  input  logic [FNW-1:0]  funct_i,
  output logic            dst_rd_o,
  output logic            reg_we_o,
  output logic            imm_sx_o,
  output logic            alu_b_imm_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            wb_mem_o,
  output logic            br_eq_o,
  output logic            br_ne_o,
  output logic            jump_o,
  output logic [ALUW-1:0] alu_code_o,
  output logic            illegal_o
);
  ctl_t     ctl_raw, ctl_q;
  alu_cls_e cls;
  alu_t     code_raw;
  logic     op_bad, fn_bad, bad;

  op_stage u_op (
    .opcode_i (opcode_i),
    .ctl_o    (ctl_raw),
    .cls_o    (cls),
    .op_bad_o (op_bad)
  );

  alu_stage u_alu (
    .cls_i    (cls),
    .funct_i  (funct_i),
    .code_o   (code_raw),
    .fn_bad_o (fn_bad)
  );

  assign bad   = op_bad | fn_bad;
  assign ctl_q = bad ? '0 : ctl_raw;

  assign dst_rd_o    = ctl_q.dst_rd;
  assign reg_we_o    = ctl_q.reg_we;
  assign imm_sx_o    = ctl_q.imm_sx;
  assign alu_b_imm_o = ctl_q.b_imm;
  assign mem_rd_o    = ctl_q.mem_rd;
  assign mem_wr_o    = ctl_q.mem_wr;
  assign wb_mem_o    = ctl_q.wb_mem;
  assign br_eq_o     = ctl_q.br_eq;
  assign br_ne_o     = ctl_q.br_ne;
  assign jump_o      = ctl_q.jump;
  assign alu_code_o  = bad ? ALU_ADD : code_raw;
  assign illegal_o   = bad;

  always_comb begin
    // R5
    mem_excl_chk: assert ($onehot0({mem_rd_o, mem_wr_o, br_eq_o, br_ne_o, jump_o}))
      else $error("more than one memory/flow control active");
    // R1
    dst_rd_chk: assert (!dst_rd_o || opcode_i == OPC_REG)
      else $error("third-field destination outside opcode 0");
    // R5
    wb_mem_chk: assert (!wb_mem_o || (mem_rd_o && reg_we_o && alu_code_o == ALU_ADD))
      else $error("memory writeback without load controls");
    // R6
    store_chk: assert (!mem_wr_o || (!reg_we_o && opcode_i == OPC_ST))
      else $error("store writes a register");
    // R10
    illegal_quiet_chk: assert (!illegal_o ||
                               !(reg_we_o || mem_wr_o || mem_rd_o || jump_o || br_eq_o || br_ne_o))
      else $error("illegal encoding left a control active");
  end
endmodule

// File: tb/test_ctrl_decode_unit.sv
module test_ctrl_decode_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode, funct;
  logic       dst_rd, reg_we, imm_sx, b_imm, mem_rd, mem_wr, wb_mem, br_eq, br_ne, jump, illegal;
  logic [3:0] alu_code;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctrl_decode_unit i_ctrl_decode_unit (
    .opcode_i(opcode), .funct_i(funct),
    .dst_rd_o(dst_rd), .reg_we_o(reg_we), .imm_sx_o(imm_sx), .alu_b_imm_o(b_imm),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .wb_mem_o(wb_mem),
    .br_eq_o(br_eq), .br_ne_o(br_ne), .jump_o(jump),
    .alu_code_o(alu_code), .illegal_o(illegal)
  );

  // bits: [14]dst [13]we [12]sx [11]bimm [10]mrd [9]mwr [8]wbm [7]beq [6]bne [5]j [4:1]alu [0]illegal
  function automatic logic [14:0] expect_vec(input logic [5:0] op, input logic [5:0] fn);
    logic [9:0] c = '0;
    logic [3:0] a = 4'b0000;
    logic       il = 1'b0;
    case (op)
      6'h00: begin
        case (fn)
          6'h20: a = 4'b0000;
          6'h22: a = 4'b0010;
          6'h24: a = 4'b0100;
          6'h25: a = 4'b0101;
          6'h26: a = 4'b0110;
          6'h2A: a = 4'b1010;
          default: il = 1'b1;
        endcase
        if (!il) c = 10'b1100000000;
      end
      6'h08: begin c = 10'b0111000000; a = 4'b0000; end
      6'h0A: begin c = 10'b0111000000; a = 4'b1010; end
      6'h0C: begin c = 10'b0101000000; a = 4'b0100; end
      6'h0D: begin c = 10'b0101000000; a = 4'b0101; end
      6'h0E: begin c = 10'b0101000000; a = 4'b0110; end
      6'h23: begin c = 10'b0111101000; a = 4'b0000; end
      6'h2B: begin c = 10'b0011010000; a = 4'b0000; end
      6'h04: begin c = 10'b0000000100; a = 4'b0010; end
      6'h05: begin c = 10'b0000000010; a = 4'b0010; end
      6'h02: begin c = 10'b0000000001; a = 4'b0000; end
      default: il = 1'b1;
    endcase
    return {c, a, il};
  endfunction

  task automatic apply_check(input logic [5:0] op, input logic [5:0] fn, input string req);
    logic [14:0] got, exp;
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    got = {dst_rd, reg_we, imm_sx, b_imm, mem_rd, mem_wr, wb_mem,
           br_eq, br_ne, jump, alu_code, illegal};
    exp = expect_vec(op, fn);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", req, op, fn, got, exp);
    end
  endtask

  // R11: state while bench reset is held, inputs at zero
  task automatic t_reset_state();
    apply_check(6'h00, 6'h00, "R11 reset-state");
  endtask

  // R1 R2 R12
  task automatic t_reg_reg();
    logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
    foreach (fns[k]) apply_check(6'h00, fns[k], "R1 R2 R12");
  endtask

  // R3 R4 R12
  task automatic t_immediates();
    logic [5:0] ops [5] = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
    foreach (ops[k]) apply_check(ops[k], 6'h00, "R3 R4");
  endtask

  // R5 R6 R9
  task automatic t_memory();
    apply_check(6'h23, 6'h00, "R5 R4");
    apply_check(6'h2B, 6'h00, "R6 R9");
  endtask

  // R7 R8 R9
  task automatic t_flow();
    apply_check(6'h04, 6'h00, "R7 R9");
    apply_check(6'h05, 6'h00, "R7");
    apply_check(6'h02, 6'h00, "R8");
  endtask

  // R13: function field varied under nonzero opcodes
  task automatic t_funct_ignored();
    logic [5:0] ops [5] = '{6'h08, 6'h0C, 6'h23, 6'h2B, 6'h04};
    foreach (ops[k]) begin
      apply_check(ops[k], 6'h22, "R13");
      apply_check(ops[k], 6'h3F, "R13");
    end
  endtask

  // R10: sweep of all opcodes not supported
  task automatic t_bad_opcodes();
    for (int o = 0; o < 64; o++) begin
      if (expect_vec(o[5:0], 6'h20) ==? 15'b??????????????1)
        apply_check(o[5:0], 6'h20, "R10");
    end
  endtask

  // R11: sweep of function codes under opcode 0
  task automatic t_bad_functs();
    for (int f = 0; f < 64; f++) apply_check(6'h00, f[5:0], "R11 R2");
  endtask

  initial begin
    opcode = 6'h00;
    funct  = 6'h00;
    repeat (3) @(posedge clk);
    t_reset_state();
    rst = 1'b0;
    t_reg_reg();
    t_immediates();
    t_memory();
    t_flow();
    t_funct_ignored();
    t_bad_opcodes();
    t_bad_functs();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule